// File: doc/BRIEF.md
# Cascadable Compare Timer

This block is a general-purpose up-counter that advances on one of several clock sources and flags the moment it reaches a programmed compare value. The clock source can be the system clock enable, the system clock enable divided by 16, an external event input, or a slow 32 kHz tick strobe. Whichever source is chosen then passes through a programmable prescaler before it reaches the counter.

When the count crosses the compare value, the block sets a sticky status flag and can raise an interrupt. It also emits a one-cycle compare pulse. Once the flag is set, software must read it before a write can clear it. In restart mode the counter returns to zero after a compare event. In free-run mode it keeps counting and wraps at its full width.

The compare pulse can be gated out through a cascade output. Feeding that output into a second instance's event input chains the two timers into a wider counter.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the count, the status flag, the interrupt request, the compare pulse and the cascade output are all 0.
- R2: While control bit 0 (enable) is 0, the count and the prescaler phase hold, whatever the tick inputs do.
- R3: Control bits 3:1 pick the tick source. Code 0 never counts. Code 1 counts `sysTick`. Code 2 counts every 16th `sysTick`. Code 3 counts `evtIn`. Codes 4 to 7 count `slowTick`. Strobes from the sources that are not selected have no effect on the count.
- R4: The counter advances once per (P+1) source ticks, where P is the value written to the prescale register from `wrData[PRE_W-1:0]`.
- R5: A compare event occurs on an increment that takes the count from below the compare value to at or above it. The event sets the status flag in the same cycle the count updates. A compare value of 0 never produces an event.
- R6: With control bit 8 at 0 (restart mode), the count reads 0 after the increment that produced a compare event.
- R7: With control bit 8 at 1 (free-run mode), the count keeps incrementing through the compare value and wraps from all ones to 0. A new event occurs only on the next crossing.
- R8: `irq` is high exactly while the status flag and control bit 4 (interrupt enable) are both 1.
- R9: `cmpPulse` is high for the single cycle after each compare event. `cascadeOut` copies it only when `cascadeSel` equals 2'b11.
- R10: A `wrStat` with `wrData[0]`=0 clears the status flag only if `rdStat` was strobed while the flag was set and no new event has occurred since. Any other status write leaves the flag set.
- R11: A counter write (`wrCnt`) loads the count with 0 and restarts both the prescaler phase and the divide-by-16 phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysTick | input | 1 | System clock enable strobe |
| slowTick | input | 1 | 32 kHz tick strobe |
| evtIn | input | 1 | External event input (cascade input) |
| cascadeSel | input | 2 | Cascade configuration; 2'b11 routes the compare pulse out |
| wrCtrl | input | 1 | Write strobe for the control register |
| wrPre | input | 1 | Write strobe for the prescale register |
| wrCmp | input | 1 | Write strobe for the compare register |
| wrCnt | input | 1 | Write strobe for the counter (loads 0) |
| wrStat | input | 1 | Write strobe for the status register |
| rdStat | input | 1 | Read strobe for the status register |
| wrData | input | DATA_W | Write data |
| count | output | CNT_W | Current count |
| statFlag | output | 1 | Compare status flag |
| irq | output | 1 | Interrupt request |
| cmpPulse | output | 1 | One-cycle compare event pulse |
| cascadeOut | output | 1 | Gated compare pulse for a second timer |

## Verification
The bench builds the block with an 8-bit counter and a 3-bit prescaler. With those widths it can sweep every prescale ratio from 1 to 8 and every small compare value. A free-run pass can also go all the way through the 256-count wrap and back into a second crossing within a few hundred ticks. Expected counts are computed arithmetically from tick totals, using floor division for the prescaler and modulo for restart and wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic step;     // advance counter by one
    logic zero;     // load counter with zero
    logic freeRun;  // keep counting through a compare event
  } tmrStrobe_t;

  localparam int CTRL_W   = 9;
  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 4;
  localparam int BIT_FREE = 8;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int DATA_W = 16,
  parameter int SYS_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysTick,
  input  logic              slowTick,
  input  logic              evtIn,
  input  logic              wrCtrl,
  input  logic              wrPre,
  input  logic              wrCnt,
  input  logic              wrStat,
  input  logic              rdStat,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hit,
  output tmrStrobe_t        strobe,
  output logic              statFlag,
  output logic              irq
);
  localparam int DIV_W = $clog2(SYS_DIV);
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(SYS_DIV - 1);

  logic [CTRL_W-1:0] ctrlReg;
  logic [PRE_W-1:0]  preLoad;
  logic [PRE_W-1:0]  preCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              readArmed;
  logic              srcPulse;
  logic              preDone;
  logic [2:0]        srcSel;
  logic              enabled;

  assign srcSel  = ctrlReg[3:1];
  assign enabled = ctrlReg[BIT_EN];

  always_comb begin
    srcPulse = 1'b0;
    if (enabled) begin
      case (srcSel)
        3'd0:    srcPulse = 1'b0;
        3'd1:    srcPulse = sysTick;
        3'd2:    srcPulse = sysTick && (divCnt == DIV_MAX);
        3'd3:    srcPulse = evtIn;
        default: srcPulse = slowTick;
      endcase
    end
  end

  assign preDone        = srcPulse && (preCnt >= preLoad);
  assign strobe.step    = preDone && !wrCnt;
  assign strobe.zero    = wrCnt;
  assign strobe.freeRun = ctrlReg[BIT_FREE];
  assign irq            = statFlag && ctrlReg[BIT_IE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      preLoad <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= wrData[CTRL_W-1:0];
      if (wrPre)  preLoad <= wrData[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      preCnt <= '0;
    end else if (wrCnt) begin
      divCnt <= '0;
      preCnt <= '0;
    end else begin
      if (enabled && srcSel == 3'd2 && sysTick)
        divCnt <= (divCnt == DIV_MAX) ? '0 : divCnt + 1'b1;
      if (srcPulse)
        preCnt <= preDone ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statFlag  <= 1'b0;
      readArmed <= 1'b0;
    end else if (hit) begin
      statFlag  <= 1'b1;
      readArmed <= 1'b0;
    end else if (wrStat && !wrData[0] && readArmed) begin
      statFlag  <= 1'b0;
      readArmed <= 1'b0;
    end else if (rdStat && statFlag) begin
      readArmed <= 1'b1;
    end
  end

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> statFlag); // R5
  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statFlag) |-> $past(readArmed) && $past(wrStat)); // R10
  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !wrCnt) |=> $stable(preCnt) && $stable(divCnt)); // R2
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic              wrCmp,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              hit,
  output logic              cmpPulse
);
  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W:0]   nextWide;
  logic [CNT_W-1:0] nextCnt;

  assign nextWide = {1'b0, count} + 1'b1;
  assign nextCnt  = nextWide[CNT_W-1:0];
  assign hit      = strobe.step && (count < cmpReg) && (nextWide >= {1'b0, cmpReg});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg <= '0;
    end else if (wrCmp) begin
      cmpReg <= wrData[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      cmpPulse <= 1'b0;
    end else begin
      cmpPulse <= hit;
      if (strobe.zero)
        count <= '0;
      else if (strobe.step)
        count <= (hit && !strobe.freeRun) ? '0 : nextCnt;
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !strobe.freeRun) |=> count == '0); // R6
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.zero) |=> $stable(count)); // R2
  AST_ZERO_CMP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cmpReg == '0) |-> !hit); // R5
  AST_FREE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && strobe.freeRun && !strobe.zero) |=> count == $past(count) + 1'b1); // R7
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int DATA_W  = 16,
  parameter int SYS_DIV = 16,
  parameter logic [1:0] CASCADE_CODE = 2'b11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysTick,
  input  logic              slowTick,
  input  logic              evtIn,
  input  logic [1:0]        cascadeSel,
  input  logic              wrCtrl,
  input  logic              wrPre,
  input  logic              wrCmp,
  input  logic              wrCnt,
  input  logic              wrStat,
  input  logic              rdStat,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              statFlag,
  output logic              irq,
  output logic              cmpPulse,
  output logic              cascadeOut
);
  tmrStrobe_t strobe;
  logic       hit;

  tmr_ctrl #(.PRE_W(PRE_W), .DATA_W(DATA_W), .SYS_DIV(SYS_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .sysTick(sysTick), .slowTick(slowTick), .evtIn(evtIn),
    .wrCtrl(wrCtrl), .wrPre(wrPre), .wrCnt(wrCnt), .wrStat(wrStat), .rdStat(rdStat),
    .wrData(wrData), .hit(hit), .strobe(strobe), .statFlag(statFlag), .irq(irq)
  );

  tmr_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrCmp(wrCmp), .wrData(wrData),
    .count(count), .hit(hit), .cmpPulse(cmpPulse)
  );

  assign cascadeOut = cmpPulse && (cascadeSel == CASCADE_CODE);

  AST_CASCADE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    cascadeOut |-> $past(hit)); // R9
endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  localparam int CNT_W = 8;
  localparam int PRE_W = 3;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sysTick = 0, slowTick = 0, evtIn = 0;
  logic [1:0] cascadeSel = 2'b00;
  logic wrCtrl = 0, wrPre = 0, wrCmp = 0, wrCnt = 0, wrStat = 0, rdStat = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [CNT_W-1:0] count;
  logic statFlag, irq, cmpPulse, cascadeOut;

  int nChecks = 0;
  int nFails = 0;

  cmp_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .sysTick(sysTick), .slowTick(slowTick), .evtIn(evtIn),
    .cascadeSel(cascadeSel), .wrCtrl(wrCtrl), .wrPre(wrPre), .wrCmp(wrCmp),
    .wrCnt(wrCnt), .wrStat(wrStat), .rdStat(rdStat), .wrData(wrData),
    .count(count), .statFlag(statFlag), .irq(irq), .cmpPulse(cmpPulse),
    .cascadeOut(cascadeOut)
  );

  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] ctrlWord(input int en, input int src,
                                                 input int ie, input int fr);
    return DATA_W'((fr << 8) | (ie << 4) | (src << 1) | en);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic k, input logic e);
    @(negedge clk); sysTick = s; slowTick = k; evtIn = e;
    @(negedge clk); sysTick = 0; slowTick = 0; evtIn = 0;
  endtask

  // which: 0 ctrl, 1 pre, 2 cmp, 3 cnt, 4 stat
  task automatic wr(input int which, input int data);
    @(negedge clk);
    wrData = DATA_W'(data);
    case (which)
      0: wrCtrl = 1; 1: wrPre = 1; 2: wrCmp = 1; 3: wrCnt = 1; default: wrStat = 1;
    endcase
    @(negedge clk);
    wrCtrl = 0; wrPre = 0; wrCmp = 0; wrCnt = 0; wrStat = 0;
  endtask

  task automatic rd();
    @(negedge clk); rdStat = 1;
    @(negedge clk); rdStat = 0;
  endtask

  task automatic clearFlag();
    rd();
    wr(4, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 flag", int'(statFlag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 pulse", int'(cmpPulse | cascadeOut), 0);
    rstN = 1;
    @(negedge clk);

    // R4 prescale sweep with R11 phase restart
    wr(2, 0);
    wr(0, ctrlWord(1, 1, 0, 0));
    for (int p = 0; p < 8; p++) begin
      wr(1, p);
      wr(3, 0);
      for (int n = 0; n < 20; n++) step(1, 0, 0);
      chk("R4 prescale count", int'(count), 20 / (p + 1));
      step(1, 0, 0);
      wr(3, 0);
      chk("R11 counter write zeros", int'(count), 0);
      for (int n = 0; n < p + 1; n++) step(1, 0, 0);
      chk("R11 prescaler phase restart", int'(count), 1);
    end

    // R2 disabled holds
    wr(1, 0);
    wr(0, ctrlWord(0, 1, 0, 0));
    for (int n = 0; n < 5; n++) step(1, 1, 1);
    chk("R2 disabled hold", int'(count), 1);
    wr(0, ctrlWord(1, 1, 0, 0));
    step(1, 0, 0);
    chk("R2 resume", int'(count), 2);

    // R3 source sweep
    for (int src = 0; src < 8; src++) begin
      wr(0, ctrlWord(1, src, 0, 0));
      wr(3, 0);
      for (int n = 0; n < 37; n++) step(1, 0, 0);
      for (int n = 0; n < 5; n++) step(0, 1, 0);
      for (int n = 0; n < 3; n++) step(0, 0, 1);
      chk("R3 source select", int'(count),
          src == 0 ? 0 : src == 1 ? 37 : src == 2 ? 2 : src == 3 ? 3 : 5);
    end

    // R5/R6 restart sweep
    wr(1, 0);
    wr(0, ctrlWord(1, 1, 0, 0));
    for (int c = 1; c <= 6; c++) begin
      wr(2, c);
      wr(3, 0);
      if (statFlag) clearFlag();
      for (int k = 1; k <= 2 * c + 1; k++) begin
        step(1, 0, 0);
        chk("R6 restart count", int'(count), k % c);
        chk("R5 flag on crossing", int'(statFlag), k >= c ? 1 : 0);
        chk("R9 pulse", int'(cmpPulse), (k % c) == 0 ? 1 : 0);
      end
    end

    // R5 compare value zero never fires
    clearFlag();
    wr(2, 0);
    wr(3, 0);
    for (int n = 0; n < 10; n++) step(1, 0, 0);
    chk("R5 zero compare count", int'(count), 10);
    chk("R5 zero compare flag", int'(statFlag), 0);

    // R7 free-run wrap and second crossing; R9 cascade gating
    cascadeSel = 2'b11;
    wr(2, 5);
    wr(0, ctrlWord(1, 1, 0, 1));
    wr(3, 0);
    for (int k = 1; k <= 300; k++) begin
      step(1, 0, 0);
      chk("R7 free-run count", int'(count), k % 256);
      chk("R9 cascade pulse", int'(cascadeOut), (k % 256) == 5 ? 1 : 0);
      chk("R7 flag", int'(statFlag), (k == 5 || k >= 261) ? 1 : 0);
      if (k == 5) clearFlag();
      if (k == 100) cascadeSel = 2'b10;
      if (k == 200) cascadeSel = 2'b11;
    end
    cascadeSel = 2'b10;
    wr(0, ctrlWord(1, 1, 0, 0));
    wr(3, 0);
    for (int n = 0; n < 5; n++) step(1, 0, 0);
    chk("R9 cascade blocked pulse", int'(cmpPulse), 1);
    chk("R9 cascade blocked out", int'(cascadeOut), 0);

    // R8 interrupt enable gating (flag is set here)
    chk("R8 irq off", int'(irq), 0);
    wr(0, ctrlWord(1, 1, 1, 0));
    chk("R8 irq on", int'(irq), 1);

    // R10 read-then-clear
    wr(4, 0);
    chk("R10 clear without read", int'(statFlag), 1);
    rd();
    wr(4, 1);
    chk("R10 write one keeps", int'(statFlag), 1);
    wr(4, 0);
    chk("R10 clear after read", int'(statFlag), 0);
    chk("R8 irq follows flag", int'(irq), 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule